// File: doc/BRIEF.md
# Link Fault Status Aggregator

This block merges the health indications of a serial receive path into one active-low link fault output. Four conditions must all be true before the link is reported good. The received amplitude must be above its trip point. The data must show enough transitions. The recovered frequency must be inside the acceptable range of ±1500 ppm. The receive channel must be enabled. If any one of them is missing, the output is driven low and the fault is signalled.

The receive enable does not act directly. It passes through a level-sensitive enable latch that has its own strobe. While the strobe is high the latch follows the enable input. When the strobe is low the latch keeps its last value, and later changes on the enable input have no effect.

In local loopback, three things change:
- The amplitude comparator is switched off.
- The amplitude condition counts as met in the combination.
- The transmit line is held at a constant logic 1, so diagnostic patterns never reach a remote receiver.

The analog comparator, the serial driver and the PLL are outside the block and appear only as plain digital signals.

Top module: `link_fault_aggregator`

## Requirements
- R1: After reset the link fault output `lnk_flt_n_o` is 0 (fault) and the channel enable `rx_chan_en_o` is 0 (disabled).
- R2: When amplitude, transition density and frequency are all valid and the channel is enabled, `lnk_flt_n_o` is 1 on the clock edge that follows.
- R3: When the transition-density flag or the frequency flag is 0, `lnk_flt_n_o` is 0 after the next clock edge. Outside loopback, the same holds for the amplitude flag.
- R4: While `rx_en_strobe_i` is 1, every clock edge copies `rx_en_i` into `rx_chan_en_o`.
- R5: While `rx_en_strobe_i` is 0, `rx_chan_en_o` keeps its value, and changes on `rx_en_i` affect neither `rx_chan_en_o` nor `lnk_flt_n_o`.
- R6: While the channel is disabled, `lnk_flt_n_o` stays 0 whatever the monitor flags are.
- R7: With `loopback_i` = 1, a 0 on `amp_ok_i` does not cause a fault.
- R8: `amp_mon_en_o` is 1 outside loopback and 0 while `loopback_i` is 1, in the same cycle.
- R9: With `loopback_i` = 1, `tx_serial_o` is 1 in the same cycle. With `loopback_i` = 0, `tx_serial_o` equals `tx_serial_i`.
- R10: The fault output is registered. It changes only on a clock edge, exactly one edge after the input change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| amp_ok_i | input | 1 | Received amplitude above trip point |
| trans_ok_i | input | 1 | Transition density sufficient |
| freq_ok_i | input | 1 | Recovered frequency within range |
| loopback_i | input | 1 | Local loopback enable |
| rx_en_i | input | 1 | Receive channel enable request |
| rx_en_strobe_i | input | 1 | Latch strobe for the enable (1 = transparent) |
| tx_serial_i | input | 1 | Serial transmit data from the serializer |
| tx_serial_o | output | 1 | Serial data toward the line driver |
| amp_mon_en_o | output | 1 | Enable for the amplitude comparator |
| rx_chan_en_o | output | 1 | Latched receive channel enable |
| lnk_flt_n_o | output | 1 | Link fault, active low |

## Verification
The bench clears each monitor flag in turn while the others stay valid. A combiner that dropped one term would then keep reporting a good link.

It closes the enable latch and then toggles the enable input. A latch that stayed transparent would show a changed channel enable or a fault output that flips.

With the channel disabled and every monitor valid, the output must still report a fault. A design that ignored the enable would report a good link here.

With loopback on and the amplitude flag low, the link must read good, the transmit line must read 1 and the comparator enable must read 0. A design that kept the amplitude term, or let data onto the line, would be caught at these ports.

// File: rtl/lfa_pkg.sv
package lfa_pkg;
   // Polarity of the fault output
   localparam logic FLT_ACTIVE = 1'b0;
   localparam logic FLT_CLEAR  = 1'b1;

   typedef struct packed {
      logic amp_ok;
      logic trans_ok;
      logic freq_ok;
   } mon_flags_t;
endpackage

// File: rtl/lfa_enable_latch.sv
module lfa_enable_latch #(
   parameter logic RESET_EN = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic strobe_i,
   output logic en_next_o,
   output logic en_q_o
);
   logic en_q;

   assign en_next_o = strobe_i ? en_i : en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= RESET_EN;
      else        en_q <= en_next_o;
   end

   assign en_q_o = en_q;

   // R4: a transparent strobe passes the input through
   assert_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> (en_q_o == $past(en_i)));

   // R5: a closed strobe holds the value
   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_i |=> $stable(en_q_o));
endmodule

// File: rtl/lfa_combiner.sv
module lfa_combiner
   import lfa_pkg::*;
#(
   parameter bit LOOPBACK_BYPASS_AMP = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  mon_flags_t flags_i,
   input  logic       loopback_i,
   input  logic       chan_en_i,
   output logic       flt_n_o
);
   logic amp_term;
   logic good;
   logic flt_n_q;

   generate
      if (LOOPBACK_BYPASS_AMP) begin : g_bypass
         assign amp_term = flags_i.amp_ok | loopback_i;
      end else begin : g_strict
         logic unused_lb;
         assign unused_lb = loopback_i;
         assign amp_term  = flags_i.amp_ok;
      end
   endgenerate

   assign good = amp_term & flags_i.trans_ok & flags_i.freq_ok & chan_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flt_n_q <= FLT_ACTIVE;
      else        flt_n_q <= good ? FLT_CLEAR : FLT_ACTIVE;
   end

   assign flt_n_o = flt_n_q;

   // R3: a missing density or frequency flag forces a fault on the next edge
   assert_monitor_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags_i.trans_ok || !flags_i.freq_ok) |=> (flt_n_o == FLT_ACTIVE));

   // R2 / R10: full agreement clears the fault one edge later
   assert_all_good_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_i.amp_ok && flags_i.trans_ok && flags_i.freq_ok && chan_en_i)
      |=> (flt_n_o == FLT_CLEAR));
endmodule

// File: rtl/lfa_tx_gate.sv
module lfa_tx_gate #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic loopback_i,
   input  logic tx_i,
   output logic tx_o,
   output logic amp_mon_en_o
);
   assign tx_o         = loopback_i ? IDLE_LEVEL : tx_i;
   assign amp_mon_en_o = ~loopback_i;
endmodule

// File: rtl/link_fault_aggregator.sv
module link_fault_aggregator
   import lfa_pkg::*;
#(
   parameter bit   LOOPBACK_BYPASS_AMP = 1'b1,
   parameter logic TX_IDLE_LEVEL       = 1'b1,
   parameter logic RESET_CHAN_EN       = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic amp_ok_i,
   input  logic trans_ok_i,
   input  logic freq_ok_i,
   input  logic loopback_i,
   input  logic rx_en_i,
   input  logic rx_en_strobe_i,
   input  logic tx_serial_i,
   output logic tx_serial_o,
   output logic amp_mon_en_o,
   output logic rx_chan_en_o,
   output logic lnk_flt_n_o
);
   generate
      if (TX_IDLE_LEVEL !== 1'b1) begin : g_bad_idle
         $error("TX_IDLE_LEVEL must hold the line at logic 1");
      end
   endgenerate

   mon_flags_t flags;
   logic       en_next;

   assign flags.amp_ok   = amp_ok_i;
   assign flags.trans_ok = trans_ok_i;
   assign flags.freq_ok  = freq_ok_i;

   lfa_enable_latch #(.RESET_EN(RESET_CHAN_EN)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (rx_en_i),
      .strobe_i (rx_en_strobe_i),
      .en_next_o(en_next),
      .en_q_o   (rx_chan_en_o)
   );

   lfa_combiner #(.LOOPBACK_BYPASS_AMP(LOOPBACK_BYPASS_AMP)) u_comb (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (flags),
      .loopback_i(loopback_i),
      .chan_en_i (en_next),
      .flt_n_o   (lnk_flt_n_o)
   );

   lfa_tx_gate #(.IDLE_LEVEL(TX_IDLE_LEVEL)) u_tx (
      .loopback_i  (loopback_i),
      .tx_i        (tx_serial_i),
      .tx_o        (tx_serial_o),
      .amp_mon_en_o(amp_mon_en_o)
   );

   // R6: a disabled channel with a closed strobe keeps the fault asserted
   assert_disabled_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_chan_en_o && !rx_en_strobe_i) |=> (lnk_flt_n_o == FLT_ACTIVE));

   // R7: loopback ignores the amplitude flag
   assert_loop_amp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (loopback_i && trans_ok_i && freq_ok_i && rx_chan_en_o && !rx_en_strobe_i)
      |=> (lnk_flt_n_o == FLT_CLEAR));

   // R8, R9: loopback silences the line and the comparator
   always_comb begin
      if (loopback_i) begin
         assert_tx_hold_R9: assert (tx_serial_o == 1'b1);
         assert_amp_off_R8: assert (amp_mon_en_o == 1'b0);
      end
   end
endmodule

// File: tb/link_fault_aggregator_tb.sv
module link_fault_aggregator_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic amp_ok = 0, trans_ok = 0, freq_ok = 0, loopback = 0;
   logic rx_en = 0, strobe = 0, tx_in = 0;
   logic tx_out, amp_mon_en, chan_en, flt_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   link_fault_aggregator u_dut (
      .clk(clk), .rst_n(rst_n),
      .amp_ok_i(amp_ok), .trans_ok_i(trans_ok), .freq_ok_i(freq_ok),
      .loopback_i(loopback), .rx_en_i(rx_en), .rx_en_strobe_i(strobe),
      .tx_serial_i(tx_in), .tx_serial_o(tx_out), .amp_mon_en_o(amp_mon_en),
      .rx_chan_en_o(chan_en), .lnk_flt_n_o(flt_n)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   // inputs change just after the falling edge; outputs are read 1 ns after the rising edge
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic drive(input logic a, input logic t, input logic f);
      @(negedge clk);
      amp_ok = a; trans_ok = t; freq_ok = f;
   endtask

   task automatic enable_channel(input logic v);
      @(negedge clk); strobe = 1; rx_en = v;
      tick();
      @(negedge clk); strobe = 0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 fault after reset", flt_n, 1'b0);
      chk("R1 channel disabled after reset", chan_en, 1'b0);
      @(negedge clk); rst_n = 1;
   endtask

   task automatic t_all_good();
      enable_channel(1'b1);
      drive(1, 1, 1);
      chk("R10 no change before edge", flt_n, 1'b0);
      tick();
      chk("R2 all good clears fault", flt_n, 1'b1);
   endtask

   task automatic t_each_fail();
      drive(1, 0, 1); tick(); chk("R3 density fail", flt_n, 1'b0);
      drive(1, 1, 1); tick(); chk("R2 recover", flt_n, 1'b1);
      drive(1, 1, 0); tick(); chk("R3 frequency fail", flt_n, 1'b0);
      drive(0, 1, 1); tick(); chk("R3 amplitude fail", flt_n, 1'b0);
      drive(1, 1, 1); tick(); chk("R2 recover again", flt_n, 1'b1);
   endtask

   task automatic t_latch();
      @(negedge clk); strobe = 1; rx_en = 0;
      tick(); chk("R4 strobe passes 0", chan_en, 1'b0);
      chk("R6 fault when disabled via pass", flt_n, 1'b0);
      @(negedge clk); rx_en = 1;
      tick(); chk("R4 strobe passes 1", chan_en, 1'b1);
      @(negedge clk); strobe = 0; rx_en = 0;
      tick(); chk("R5 held while closed", chan_en, 1'b1);
      chk("R5 fault unaffected while closed", flt_n, 1'b1);
      tick(); chk("R5 still held", chan_en, 1'b1);
   endtask

   task automatic t_disabled();
      enable_channel(1'b0);
      rx_en = 1;
      drive(1, 1, 1);
      for (int i = 0; i < 4; i++) begin
         tick(); chk("R6 disabled keeps fault", flt_n, 1'b0);
      end
      chk("R5 disabled held", chan_en, 1'b0);
   endtask

   task automatic t_loopback();
      enable_channel(1'b1);
      @(negedge clk); loopback = 1; tx_in = 0;
      amp_ok = 0; trans_ok = 1; freq_ok = 1;
      #1;
      chk("R9 tx forced high", tx_out, 1'b1);
      chk("R8 amplitude monitor off", amp_mon_en, 1'b0);
      tick(); chk("R7 amplitude ignored", flt_n, 1'b1);
      drive(0, 0, 1); tick(); chk("R3 density fail in loopback", flt_n, 1'b0);
      @(negedge clk); loopback = 0; amp_ok = 0; trans_ok = 1; tx_in = 0;
      #1;
      chk("R9 tx follows data 0", tx_out, 1'b0);
      chk("R8 amplitude monitor on", amp_mon_en, 1'b1);
      @(negedge clk); tx_in = 1; #1;
      chk("R9 tx follows data 1", tx_out, 1'b1);
      tick(); chk("R7 amplitude counts outside loopback", flt_n, 1'b0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      t_reset();
      t_all_good();
      t_each_fail();
      t_latch();
      t_disabled();
      t_loopback();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule